// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a 32-bit physical address. It walks a two-level table held in memory. A requester hands it one virtual address at a time over a valid/ready handshake. The walker then reads the first-level entry, followed by the second-level (leaf) entry, through a word-wide request/response memory port. It returns a single-cycle response that carries either the physical address with its 4-bit access-control index, or a fault code.

The first-level table base comes from a base register, which is written through a small write port. Only one table is active at a time. Each table level has its own captured fault address with a pending flag. A captured address stays unchanged until its flag is cleared through the clear input, so the first fault of each level is preserved for inspection.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress, and every accepted request produces exactly one response, which is a one-cycle `rsp_valid` pulse.
- R2: The first memory read addresses `base + va[31:20]*4`. The base is the value of the base register at the clock edge that accepts the request, and a `base_we` write changes it for requests accepted afterwards.
- R3: A first-level entry is valid only when its bits 1:0 equal 2'b01. Any other value ends the walk with `rsp_fault` = 2'b01, and no second read is issued.
- R4: The second memory read addresses `{l1[31:10], 10'b0} + va[19:12]*4`. Bits 9:2 of the first-level entry do not affect it.
- R5: A leaf entry is valid only when its bit 1 is set. Otherwise the walk ends with `rsp_fault` = 2'b10.
- R6: A successful walk returns `rsp_fault` = 2'b00, `rsp_pa = {leaf[31:12], va[11:0]}` and `rsp_aci = leaf[7:4]`.
- R7: A fault at level 1 (or level 2) captures the virtual address in `fault_l1_va` (or `fault_l2_va`) and sets the matching pending flag. This happens only if that flag was clear, so a later fault of the same level does not overwrite the captured address.
- R8: `fault_clr[0]` clears the level-1 pending flag and `fault_clr[1]` clears the level-2 one. A new fault of that level in the same cycle as its clear is captured.
- R9: A translation and a fault are never reported together. The code 2'b11 never appears, and on a fault response `rsp_pa` and `rsp_aci` are zero.
- R10: A memory request, once raised, keeps `mem_req_valid` high and `mem_req_addr` stable until `mem_req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the first-level base register |
| base_wdata | input | 32 | New first-level table base |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_va | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_aci | output | 4 | Access-control index (zero on fault) |
| rsp_fault | output | 2 | 00 ok, 01 invalid level-1 entry, 10 invalid leaf |
| fault_clr | input | 2 | Bit 0 clears level-1 pending, bit 1 level-2 |
| fault_l1_pend | output | 1 | Level-1 fault captured |
| fault_l1_va | output | 32 | Captured level-1 faulting address |
| fault_l2_pend | output | 1 | Level-2 fault captured |
| fault_l2_va | output | 32 | Captured level-2 faulting address |

## Verification
The first memory request rises one cycle after the accepting edge. Each later step moves forward one cycle after the memory handshake or read data that feeds it. `rsp_valid`, together with the fault capture, follows the consumed entry by exactly one edge, and a clear takes effect on the next edge. The bench drives all inputs on falling edges and samples outputs on falling edges. It waits for the `rsp_valid` pulse and only then compares the response, the two recorded memory addresses and the fault registers against its own model of the table walk and capture rules.

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int L1W = 12,
  parameter int L2W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_we,
  input  logic [31:0] base_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        rsp_valid,
  output logic [31:0] rsp_pa,
  output logic [3:0]  rsp_aci,
  output logic [1:0]  rsp_fault,
  input  logic [1:0]  fault_clr,
  output logic        fault_l1_pend,
  output logic [31:0] fault_l1_va,
  output logic        fault_l2_pend,
  output logic [31:0] fault_l2_va
);
  localparam int OFFW  = 32 - L1W - L2W;
  localparam int ALIGN = L2W + 2;

  typedef enum logic [2:0] {S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE, S_FAULT} state_t;

  state_t      state;
  logic [31:0] base_q, va_q, addr_q, pa_q;
  logic [3:0]  aci_q;
  logic [1:0]  code_q;

  logic [31:0] l1_off, l2_off, pt_base;
  logic        l1_ok, l2_ok, l1_bad, l2_bad;

  assign l1_off  = {{(30-L1W){1'b0}}, req_va[31 -: L1W], 2'b00};
  assign l2_off  = {{(30-L2W){1'b0}}, va_q[OFFW +: L2W], 2'b00};
  assign pt_base = {mem_rsp_data[31:ALIGN], {ALIGN{1'b0}}};
  assign l1_ok   = mem_rsp_data[1:0] == 2'b01;
  assign l2_ok   = mem_rsp_data[1];
  assign l1_bad  = (state == S_L1_WAIT) && mem_rsp_valid && !l1_ok;
  assign l2_bad  = (state == S_L2_WAIT) && mem_rsp_valid && !l2_ok;

  assign req_ready     = state == S_IDLE;
  assign mem_req_valid = (state == S_L1_REQ) || (state == S_L2_REQ);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state == S_DONE) || (state == S_FAULT);
  assign rsp_pa        = (state == S_DONE) ? pa_q : '0;
  assign rsp_aci       = (state == S_DONE) ? aci_q : '0;
  assign rsp_fault     = (state == S_FAULT) ? code_q : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      va_q   <= '0;
      addr_q <= '0;
      pa_q   <= '0;
      aci_q  <= '0;
      code_q <= 2'b00;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          addr_q <= base_q + l1_off;
          state  <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) state <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          if (l1_ok) begin
            addr_q <= pt_base + l2_off;
            state  <= S_L2_REQ;
          end else begin
            code_q <= 2'b01;
            state  <= S_FAULT;
          end
        end
        S_L2_REQ: if (mem_req_ready) state <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          if (l2_ok) begin
            pa_q   <= {mem_rsp_data[31:OFFW], va_q[OFFW-1:0]};
            aci_q  <= mem_rsp_data[7:4];
            code_q <= 2'b00;
            state  <= S_DONE;
          end else begin
            code_q <= 2'b10;
            state  <= S_FAULT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_l1_pend <= 1'b0;
      fault_l1_va   <= '0;
    end else if (l1_bad && (!fault_l1_pend || fault_clr[0])) begin
      fault_l1_pend <= 1'b1;
      fault_l1_va   <= va_q;
    end else if (fault_clr[0]) begin
      fault_l1_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_l2_pend <= 1'b0;
      fault_l2_va   <= '0;
    end else if (l2_bad && (!fault_l2_pend || fault_clr[1])) begin
      fault_l2_pend <= 1'b1;
      fault_l2_va   <= va_q;
    end else if (fault_clr[1]) begin
      fault_l2_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_pa,
  input logic [3:0]  rsp_aci,
  input logic [1:0]  rsp_fault,
  input logic [1:0]  fault_clr,
  input logic        fault_l1_pend,
  input logic [31:0] fault_l1_va,
  input logic        fault_l2_pend,
  input logic [31:0] fault_l2_va
);
  logic busy;
  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else if (req_valid && req_ready) busy <= 1'b1;
    else if (rsp_valid) busy <= 1'b0;
  end

  a_r1_rsp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);
  a_r1_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r1_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);
  a_r9_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_pa == '0 && rsp_aci == '0));
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r7_l1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_l1_pend && !fault_clr[0]) |=> (fault_l1_pend && $stable(fault_l1_va)));
  a_r7_l2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_l2_pend && !fault_clr[1]) |=> (fault_l2_pend && $stable(fault_l2_va)));
  a_r7_l1_set_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b01) |-> fault_l1_pend);
  a_r7_l2_set_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b10) |-> fault_l2_pend);
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_aci(rsp_aci), .rsp_fault(rsp_fault),
  .fault_clr(fault_clr), .fault_l1_pend(fault_l1_pend), .fault_l1_va(fault_l1_va),
  .fault_l2_pend(fault_l2_pend), .fault_l2_va(fault_l2_va)
);

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_aci;
  logic [1:0]  rsp_fault;
  logic [1:0]  fault_clr = 2'b00;
  logic        fault_l1_pend, fault_l2_pend;
  logic [31:0] fault_l1_va, fault_l2_va;

  always #2 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_aci(rsp_aci), .rsp_fault(rsp_fault),
    .fault_clr(fault_clr), .fault_l1_pend(fault_l1_pend), .fault_l1_va(fault_l1_va),
    .fault_l2_pend(fault_l2_pend), .fault_l2_va(fault_l2_va)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] base_m = '0;
  logic        m1_pend = 0, m2_pend = 0;
  logic [31:0] m1_va = '0, m2_va = '0;
  logic [31:0] seen [2];
  int          n_seen = 0;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [31:0] x;
    x = a ^ 32'h5bd1e995;
    x = x * 32'h9E3779B1;
    x = x ^ (x >> 16);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return x;
  endfunction

  function automatic logic [1:0] exp_code(logic [31:0] va, logic [31:0] b);
    logic [31:0] e1, e2;
    e1 = mem_word(b + {18'd0, va[31:20], 2'b00});
    if (e1[1:0] != 2'b01) return 2'b01;
    e2 = mem_word({e1[31:10], 10'd0} + {22'd0, va[19:12], 2'b00});
    if (!e2[1]) return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = ($urandom % 4) != 0;
      @(posedge clk);
      if (mem_req_valid && mem_req_ready) begin
        logic [31:0] a;
        int d;
        a = mem_req_addr;
        if (n_seen < 2) seen[n_seen] = a;
        n_seen++;
        d = $urandom % 3;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (d) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(a);
        @(posedge clk);
      end
    end
  end

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    base_m = b;
  endtask

  task automatic clear(input logic [1:0] v);
    @(negedge clk);
    fault_clr = v;
    @(negedge clk);
    fault_clr = 2'b00;
    if (v[0]) m1_pend = 0;
    if (v[1]) m2_pend = 0;
    chk(fault_l1_pend == m1_pend, "R8 l1 pend after clear", {31'd0, fault_l1_pend}, {31'd0, m1_pend});
    chk(fault_l2_pend == m2_pend, "R8 l2 pend after clear", {31'd0, fault_l2_pend}, {31'd0, m2_pend});
  endtask

  task automatic xlat(input logic [31:0] va);
    logic [31:0] e1, e2, a1, a2, epa;
    logic [1:0]  ec;
    logic [3:0]  eaci;
    int          wait_n;
    e1 = mem_word(base_m + {18'd0, va[31:20], 2'b00});
    a1 = base_m + {18'd0, va[31:20], 2'b00};
    a2 = {e1[31:10], 10'd0} + {22'd0, va[19:12], 2'b00};
    e2 = mem_word(a2);
    ec = exp_code(va, base_m);
    epa  = (ec == 2'b00) ? {e2[31:12], va[11:0]} : 32'd0;
    eaci = (ec == 2'b00) ? e2[7:4] : 4'd0;
    @(negedge clk);
    chk(req_ready, "R1 ready when idle", {31'd0, req_ready}, 32'd1);
    n_seen = 0;
    req_valid = 1'b1;
    req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 busy after accept", {31'd0, req_ready}, 32'd0);
    wait_n = 0;
    while (!rsp_valid && wait_n < 60) begin
      @(negedge clk);
      wait_n++;
    end
    chk(rsp_valid, "R1 response arrives", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_fault == ec, "R3/R5/R9 fault code", {30'd0, rsp_fault}, {30'd0, ec});
    chk(rsp_pa == epa, "R6 physical address", rsp_pa, epa);
    chk(rsp_aci == eaci, "R6 access index", {28'd0, rsp_aci}, {28'd0, eaci});
    chk(seen[0] == a1, "R2 level-1 read address", seen[0], a1);
    if (ec == 2'b01) begin
      chk(n_seen == 1, "R3 no second read", n_seen, 1);
      if (!m1_pend) begin m1_pend = 1; m1_va = va; end
    end else begin
      chk(n_seen == 2, "R4 two reads", n_seen, 2);
      chk(seen[1] == a2, "R4 level-2 read address", seen[1], a2);
      if (ec == 2'b10 && !m2_pend) begin m2_pend = 1; m2_va = va; end
    end
    chk(fault_l1_pend == m1_pend, "R7 l1 pend", {31'd0, fault_l1_pend}, {31'd0, m1_pend});
    chk(fault_l2_pend == m2_pend, "R7 l2 pend", {31'd0, fault_l2_pend}, {31'd0, m2_pend});
    if (m1_pend) chk(fault_l1_va == m1_va, "R7 l1 captured va", fault_l1_va, m1_va);
    if (m2_pend) chk(fault_l2_va == m2_va, "R7 l2 captured va", fault_l2_va, m2_va);
    @(negedge clk);
    chk(!rsp_valid, "R1 single pulse", {31'd0, rsp_valid}, 32'd0);
  endtask

  function automatic logic [31:0] find_va(input logic [1:0] want, input logic [31:0] seed);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] v;
      v = mem_word(seed + i);
      if (exp_code(v, base_m) == want) return v;
    end
    return seed;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk(!rsp_valid, "R1 reset no response", {31'd0, rsp_valid}, 32'd0);
    chk(!mem_req_valid, "R10 reset no mem request", {31'd0, mem_req_valid}, 32'd0);
    chk(!fault_l1_pend && !fault_l2_pend, "R7 reset pend clear", {30'd0, fault_l1_pend, fault_l2_pend}, 32'd0);

    set_base(32'h4000_0000);
    xlat(find_va(2'b00, 32'h100));
    xlat(find_va(2'b00, 32'h900));
    xlat(find_va(2'b01, 32'h200));
    xlat(find_va(2'b01, 32'h300));
    xlat(find_va(2'b10, 32'h400));
    xlat(find_va(2'b10, 32'h500));
    clear(2'b01);
    xlat(find_va(2'b01, 32'h600));
    clear(2'b11);
    xlat(find_va(2'b10, 32'h700));
    set_base(32'h1234_5678 & 32'hFFFF_FFFC);
    xlat(find_va(2'b00, 32'h800));
    xlat(32'h0000_0000);
    xlat(32'hFFFF_FFFF);

    for (int n = 0; n < 300; n++) begin
      if (($urandom % 8) == 0) clear($urandom % 4);
      if (($urandom % 50) == 0) set_base($urandom & 32'hFFFF_FFFC);
      xlat($urandom);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule